// File: doc/BRIEF.md
# Three-Operand Adder Pipeline

This block is a five-stage in-order pipeline whose only operation is `R <= X + Y + Z`, where X, Y and Z are read from a small register file. It has five stages: fetch, decode, a first execute stage, a second execute stage and write-back. The first execute stage adds X and Y. The second adds Z. A write-back-after stage sits behind write-back and keeps the most recently retired result on hand for late forwarding. Instructions come from an external instruction memory. The block drives the fetch address and samples the returned instruction word in the same cycle.

Read-after-write hazards are detected and resolved in the first execute stage, not in decode. An X or Y operand that depends on the instruction one slot ahead stalls the first execute stage for exactly one cycle. A Z operand never stalls: it is forwarded a second time in the second execute stage. Other dependences are covered in one of two ways. The first is forwarding from write-back or write-back-after, with the youngest producer winning. The second is the register file's internal write-to-read bypass.

Top module: `tri_add_pipe`

## Requirements
- R1: During and right after a synchronous reset, `pc_o` is 0 and `wb_we_o` is low. Every register then holds its own index as its value (register k holds k).
- R2: Each valid instruction writes `X + Y + Z`, taken modulo 2^DW, to its destination register. Writes occur exactly once per valid instruction and in program order, and appear on `wb_we_o`/`wb_rd_o`/`wb_data_o`.
- R3: Instruction word layout is: bit 4*AW is the valid flag; bits [4*AW-1:3*AW] are the destination; [3*AW-1:2*AW] is the X source; [2*AW-1:AW] is the Y source; [AW-1:0] is the Z source. A word with the valid flag at 0 writes nothing.
- R4: A stall occurs when the X or Y source of a valid instruction equals the destination of the valid instruction fetched just before it. In that case `stall_o` is high for exactly one cycle, `pc_o` holds for that cycle, and one write-back slot is empty.
- R5: A Z source that depends on the instruction just ahead causes no stall and still yields the correct sum.
- R6: Dependences on instructions two or three slots ahead cause no stall and yield correct sums.
- R7: When several in-flight instructions target the same register, a consumer receives the value of the youngest one that is older than itself.
- R8: An operand whose producer is two slots ahead stays correct when the same consumer also stalls on its other operand.
- R9: Without stalls, `pc_o` advances by one each cycle, and independent instructions retire on consecutive cycles.
- R10: An instruction word marked not valid never causes a stall or a forward, whatever its register fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | PCW | Fetch address to the instruction memory |
| instr_i | input | 4*AW+1 | Instruction word for `pc_o`, returned in the same cycle |
| stall_o | output | 1 | First execute stage is holding this cycle |
| wb_we_o | output | 1 | Write-back stage holds a valid result |
| wb_rd_o | output | AW | Destination register of the write-back result |
| wb_data_o | output | DW | Write-back result value |

## Verification
The assertions assume that `instr_i` is a pure function of `pc_o` within a cycle, so a held address during a stall sees the same word again. They also assume reset is held for at least one clock edge before the first check. The bench drives `instr_i` combinationally from a program array indexed by `pc_o`, and returns all-zero (not valid) words past the end of the program. It asserts reset for several cycles before each program, so the pc and bubble properties start only from a known pipeline state.

// File: rtl/tri_add_pkg.sv
package tri_add_pkg;
  // Where an execute-stage operand is taken from
  typedef enum logic [1:0] {
    SEL_REG = 2'd0,
    SEL_WB  = 2'd1,
    SEL_WBA = 2'd2
  } opsrc_e;
endpackage

// File: rtl/tap_regfile.sv
// Three read ports, one write port, write-to-read bypass on every read port.
module tap_regfile #(
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int NR = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          wa,
  input  logic [DW-1:0]          wd,
  input  logic [NR-1:0][AW-1:0]  ra,
  output logic [NR-1:0][DW-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(i);
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  for (genvar p = 0; p < NR; p++) begin : g_rd
    always_comb begin
      if (we && (wa == ra[p])) rdata[p] = wd;
      else                     rdata[p] = mem[ra[p]];
    end
  end
endmodule

// File: rtl/tap_opsel.sv
// First-execute operand selection for one adder input: three comparisons.
module tap_opsel
  import tri_add_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic [AW-1:0] src,
  input  logic [DW-1:0] reg_val,
  input  logic          ex2_v,
  input  logic [AW-1:0] ex2_rd,
  input  logic          wb_v,
  input  logic [AW-1:0] wb_rd,
  input  logic [DW-1:0] wb_d,
  input  logic          wba_v,
  input  logic [AW-1:0] wba_rd,
  input  logic [DW-1:0] wba_d,
  output logic          ex2_hit,
  output logic [DW-1:0] opnd
);
  opsrc_e sel;

  assign ex2_hit = ex2_v && (src == ex2_rd);

  always_comb begin
    if (wb_v && (src == wb_rd))        sel = SEL_WB;
    else if (wba_v && (src == wba_rd)) sel = SEL_WBA;
    else                               sel = SEL_REG;
  end

  always_comb begin
    unique case (sel)
      SEL_WB:  opnd = wb_d;
      SEL_WBA: opnd = wba_d;
      default: opnd = reg_val;
    endcase
  end
endmodule

// File: rtl/tri_add_pipe.sv
module tri_add_pipe #(
  parameter int DW  = 16,
  parameter int AW  = 3,
  parameter int PCW = 6
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PCW-1:0]  pc_o,
  input  logic [4*AW:0]   instr_i,
  output logic            stall_o,
  output logic            wb_we_o,
  output logic [AW-1:0]   wb_rd_o,
  output logic [DW-1:0]   wb_data_o
);
  localparam int VB = 4 * AW;   // valid flag position
  localparam int NS = 3;        // source operands

  // fetch
  logic [PCW-1:0] pc_q;
  // decode
  logic                   id_v;
  logic [AW-1:0]          id_rd;
  logic [NS-1:0][AW-1:0]  id_src;
  logic [NS-1:0][DW-1:0]  id_val;
  logic                   id_zm_ex1, id_zm_ex2;
  // first execute
  logic                   ex1_v;
  logic [AW-1:0]          ex1_rd;
  logic [1:0][AW-1:0]     ex1_src;
  logic [NS-1:0][DW-1:0]  ex1_val;
  logic                   ex1_zm2, ex1_zwb;
  logic [1:0][DW-1:0]     ex1_op;
  logic [1:0]             ex1_hit;
  logic [DW-1:0]          z1_val;
  logic                   stall;
  // second execute
  logic                   ex2_v, ex2_zfwd;
  logic [AW-1:0]          ex2_rd;
  logic [DW-1:0]          ex2_sum, ex2_z, ex2_res;
  // write-back and write-back-after
  logic                   wb_v, wba_v;
  logic [AW-1:0]          wb_rd, wba_rd;
  logic [DW-1:0]          wb_d, wba_d;

  // ---------------- fetch ----------------
  always_ff @(posedge clk) begin
    if (rst)         pc_q <= '0;
    else if (!stall) pc_q <= pc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_v   <= 1'b0;
      id_rd  <= '0;
      id_src <= '0;
    end else if (!stall) begin
      id_v      <= instr_i[VB];
      id_rd     <= instr_i[VB-1 -: AW];
      id_src[0] <= instr_i[3*AW-1 -: AW];
      id_src[1] <= instr_i[2*AW-1 -: AW];
      id_src[2] <= instr_i[AW-1 -: AW];
    end
  end

  // ---------------- decode ----------------
  tap_regfile #(.DW(DW), .AW(AW), .NR(NS)) u_rf (
    .clk(clk), .rst(rst),
    .we(wb_v), .wa(wb_rd), .wd(wb_d),
    .ra(id_src), .rdata(id_val)
  );

  // Z comparisons made early; meaning fixed by where the producer lands
  assign id_zm_ex1 = id_v && ex1_v && (id_src[2] == ex1_rd);
  assign id_zm_ex2 = id_v && ex2_v && (id_src[2] == ex2_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      ex1_v   <= 1'b0;
      ex1_rd  <= '0;
      ex1_src <= '0;
      ex1_val <= '0;
      ex1_zm2 <= 1'b0;
      ex1_zwb <= 1'b0;
    end else if (!stall) begin
      ex1_v      <= id_v;
      ex1_rd     <= id_rd;
      ex1_src[0] <= id_src[0];
      ex1_src[1] <= id_src[1];
      ex1_val    <= id_val;
      ex1_zm2    <= id_zm_ex1;
      ex1_zwb    <= id_zm_ex2;
    end else begin
      // held: refresh Z and age its flags by one stage
      ex1_val[2] <= z1_val;
      ex1_zwb    <= ex1_zm2;
      ex1_zm2    <= 1'b0;
    end
  end

  // ---------------- first execute ----------------
  for (genvar k = 0; k < 2; k++) begin : g_xy
    tap_opsel #(.DW(DW), .AW(AW)) u_sel (
      .src(ex1_src[k]), .reg_val(ex1_val[k]),
      .ex2_v(ex2_v), .ex2_rd(ex2_rd),
      .wb_v(wb_v), .wb_rd(wb_rd), .wb_d(wb_d),
      .wba_v(wba_v), .wba_rd(wba_rd), .wba_d(wba_d),
      .ex2_hit(ex1_hit[k]), .opnd(ex1_op[k])
    );
  end

  assign stall  = ex1_v && (|ex1_hit);
  assign z1_val = ex1_zwb ? wb_d : ex1_val[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ex2_v    <= 1'b0;
      ex2_rd   <= '0;
      ex2_sum  <= '0;
      ex2_z    <= '0;
      ex2_zfwd <= 1'b0;
    end else begin
      ex2_v    <= ex1_v && !stall;
      ex2_rd   <= ex1_rd;
      ex2_sum  <= ex1_op[0] + ex1_op[1];
      ex2_z    <= z1_val;
      ex2_zfwd <= ex1_zm2 && !stall;
    end
  end

  // ---------------- second execute ----------------
  assign ex2_res = ex2_sum + (ex2_zfwd ? wb_d : ex2_z);

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_v  <= 1'b0;
      wb_rd <= '0;
      wb_d  <= '0;
      wba_v <= 1'b0;
      wba_rd <= '0;
      wba_d <= '0;
    end else begin
      wb_v   <= ex2_v;
      wb_rd  <= ex2_rd;
      wb_d   <= ex2_res;
      wba_v  <= wb_v;
      wba_rd <= wb_rd;
      wba_d  <= wb_d;
    end
  end

  assign pc_o      = pc_q;
  assign stall_o   = stall;
  assign wb_we_o   = wb_v;
  assign wb_rd_o   = wb_rd;
  assign wb_data_o = wb_d;
endmodule

// File: rtl/tri_add_pipe_chk.sv
module tri_add_pipe_chk #(
  parameter int PCW = 6
) (
  input logic           clk,
  input logic           rst,
  input logic [PCW-1:0] pc_o,
  input logic           stall_o,
  input logic           wb_we_o
);
  // R1
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && !wb_we_o));

  // R4
  p_single_stall_r4: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> !stall_o);

  // R4
  p_pc_hold_r4: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> $stable(pc_o));

  // R4
  p_empty_slot_r4: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> ##1 !wb_we_o);

  // R9
  p_pc_step_r9: assert property (@(posedge clk) disable iff (rst)
    !stall_o |=> pc_o == PCW'($past(pc_o) + 1'b1));
endmodule

bind tri_add_pipe tri_add_pipe_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .rst(rst), .pc_o(pc_o), .stall_o(stall_o), .wb_we_o(wb_we_o)
);

// File: tb/tri_add_pipe_test.sv
`timescale 1ns/1ps
module tri_add_pipe_test;
  localparam int DW = 16, AW = 3, PCW = 6, IW = 4*AW+1, PMAX = 32, NT = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [PCW-1:0] pc_o;
  logic [IW-1:0]  instr_i;
  logic stall_o, wb_we_o;
  logic [AW-1:0] wb_rd_o;
  logic [DW-1:0] wb_data_o;

  logic [IW-1:0] prog [PMAX];
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  assign instr_i = (int'(pc_o) < PMAX) ? prog[pc_o] : '0;

  tri_add_pipe #(.DW(DW), .AW(AW), .PCW(PCW)) uut (
    .clk(clk), .rst(rst), .pc_o(pc_o), .instr_i(instr_i), .stall_o(stall_o),
    .wb_we_o(wb_we_o), .wb_rd_o(wb_rd_o), .wb_data_o(wb_data_o)
  );

  function automatic logic [IW-1:0] mk(bit v, int rd, int x, int y, int z);
    return {v, AW'(rd), AW'(x), AW'(y), AW'(z)};
  endfunction

  // Stimulus table: instruction word and the hand-derived stall flag
  localparam logic [IW-1:0] TBL [NT] = '{
    {1'b1,3'd1,3'd2,3'd3,3'd4}, {1'b1,3'd5,3'd1,3'd0,3'd0},
    {1'b1,3'd6,3'd0,3'd0,3'd5}, {1'b1,3'd7,3'd0,3'd5,3'd0},
    {1'b1,3'd2,3'd7,3'd6,3'd0}, {1'b1,3'd3,3'd2,3'd2,3'd2},
    {1'b1,3'd3,3'd1,3'd1,3'd1}, {1'b1,3'd4,3'd3,3'd0,3'd3},
    {1'b0,3'd4,3'd4,3'd4,3'd4}, {1'b1,3'd0,3'd4,3'd4,3'd4},
    {1'b1,3'd1,3'd0,3'd3,3'd2}, {1'b1,3'd2,3'd5,3'd6,3'd1},
    {1'b1,3'd5,3'd2,3'd1,3'd5}, {1'b1,3'd6,3'd6,3'd7,3'd5},
    {1'b1,3'd7,3'd7,3'd6,3'd6}, {1'b1,3'd0,3'd1,3'd2,3'd3}
  };
  localparam bit TSTALL [NT] = '{0,1,0,0,1,1,0,1,0,0,1,0,1,0,1,0};

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs prog[0..n-1]; checks every write-back against a register model.
  task automatic run_prog(int n, int exp_stalls, string req,
                          output int first_w, output int last_w);
    logic [DW-1:0] mdl [1 << AW];
    logic [AW-1:0] erd [PMAX];
    logic [DW-1:0] edat [PMAX];
    int ne = 0, got = 0, stalls = 0, cyc = 0;
    bit pstall = 0;
    logic [PCW-1:0] ppc = '0;
    for (int i = 0; i < (1 << AW); i++) mdl[i] = DW'(i);
    for (int i = 0; i < n; i++) begin
      logic [IW-1:0] w = prog[i];
      if (w[4*AW]) begin
        logic [AW-1:0] d = w[4*AW-1 -: AW];
        logic [DW-1:0] s = mdl[w[3*AW-1 -: AW]] + mdl[w[2*AW-1 -: AW]] + mdl[w[AW-1:0]];
        mdl[d] = s; erd[ne] = d; edat[ne] = s; ne++;
      end
    end
    first_w = -1; last_w = -1;
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 2*n + 12; c++) begin
      @(negedge clk);
      cyc++;
      if (pstall) check(pc_o == ppc, "R4", "pc held in stall", pc_o, ppc);
      if (stall_o) stalls++;
      pstall = stall_o; ppc = pc_o;
      if (wb_we_o) begin
        if (got < ne) begin
          check(wb_rd_o == erd[got], req, $sformatf("dest of write %0d", got), wb_rd_o, erd[got]);
          check(wb_data_o == edat[got], req, $sformatf("value of write %0d", got), wb_data_o, edat[got]);
        end
        if (first_w < 0) first_w = cyc;
        last_w = cyc;
        got++;
      end
    end
    check(got == ne, "R2", "number of writes", got, ne);
    check(stalls == exp_stalls, "R4", "stall cycles", stalls, exp_stalls);
  endtask

  initial begin
    int fw, lw, es;
    for (int i = 0; i < PMAX; i++) prog[i] = '0;
    // R1: reset state
    repeat (2) @(negedge clk);
    check(pc_o == '0, "R1", "pc in reset", pc_o, 0);
    check(!wb_we_o, "R1", "no write in reset", wb_we_o, 0);

    // Table walk: R2 R3 R5 R6 R7 R8 R10 (R10: entry 8 is not valid)
    es = 0;
    for (int i = 0; i < NT; i++) begin
      prog[i] = TBL[i];
      es += int'(TSTALL[i]);
    end
    run_prog(NT, es, "R2/R5/R6/R7/R8/R10", fw, lw);

    // R1: register k starts at k, read with no dependences
    for (int i = 0; i < PMAX; i++) prog[i] = '0;
    prog[0] = mk(1, 0, 7, 6, 5);
    run_prog(1, 0, "R1", fw, lw);

    // R9: independent instructions retire back to back
    for (int i = 0; i < PMAX; i++) prog[i] = '0;
    for (int i = 0; i < 6; i++) prog[i] = mk(1, 4 + (i % 4), 1, 2, 3);
    run_prog(6, 0, "R9", fw, lw);
    check(lw - fw == 5, "R9", "cycles first to last write", lw - fw, 5);

    // R2 wrap and R4 on every step: r1 tripled repeatedly
    for (int i = 0; i < PMAX; i++) prog[i] = '0;
    for (int i = 0; i < 12; i++) prog[i] = mk(1, 1, 1, 1, 1);
    run_prog(12, 11, "R2", fw, lw);

    // R10: not-valid words that name the consumer's sources
    for (int i = 0; i < PMAX; i++) prog[i] = '0;
    prog[0] = mk(1, 2, 3, 3, 3);
    prog[1] = mk(0, 5, 0, 0, 0);
    prog[2] = mk(1, 6, 5, 5, 2);
    prog[3] = mk(0, 6, 1, 1, 1);
    prog[4] = mk(1, 7, 6, 6, 6);
    run_prog(5, 0, "R10", fw, lw);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule